// File: doc/BRIEF.md
# Step and Direction Pulse Generator

This block drives an external stepper driver. A host or motion engine raises a one-cycle request strobe together with a direction bit. Each accepted request becomes exactly one step pulse on the step output, plus a direction level on the direction output. The width of the step pulse is set in clock cycles by a configuration input. A second configuration input chooses which level of the step line counts as asserted.

When a request needs the opposite direction from the one currently driven, the direction output changes first. The step edge then waits a fixed number of clocks, so the driver sees a settled direction before it latches a step. Every step the block emits also moves an internal position count by one, up or down according to the direction. The count therefore follows the commanded motion with no feedback path and no filter.

A request that arrives while a pulse, its trailing gap or a direction setup is still running is held and served as soon as the generator is free. The busy output stays high for that whole time. Only one request can be held.

Top module: `step_dir_gen`

## Requirements
- R1: While reset is low and on the first cycle after it, the step output sits at its inactive level, the direction output is 0, the position count is 0 and busy is 0.
- R2: A step pulse stays at its asserted level for exactly the configured width in clock cycles; a configured width of 0 gives a pulse of one cycle.
- R3: With the polarity input at 1 the step output is high while asserted and low otherwise; with it at 0 the levels are swapped, including when the block is idle.
- R4: When a request's direction differs from the driven direction, the direction output changes on the clock edge that accepts it, and the step asserts exactly SETUP_CYC clock edges later; the direction output never changes while a step is asserted.
- R5: The position count changes on the same edge on which the step output becomes asserted: plus one when the direction output is 1, minus one when it is 0. At no other time does it change.
- R6: Two consecutive step pulses are separated by at least the configured width of inactive step level.
- R7: A request accepted while idle whose direction equals the driven direction asserts the step on the very next clock edge.
- R8: A request that arrives while busy is high is held and later emitted as a normal step, in its own direction, and busy is high while it is held. Any further request arriving while one is already held is ignored.
- R9: The position count is POS_W bits wide and wraps modulo 2^POS_W: one down step from 0 gives all ones, and one up step from all ones gives 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | One-cycle step request strobe |
| req_dir_i | input | 1 | Direction of the request, 1 counts up |
| cfg_width_i | input | WIDTH_W | Step pulse width in clock cycles, 0 treated as 1 |
| cfg_active_high_i | input | 1 | 1: step asserted high, 0: step asserted low |
| step_o | output | 1 | Step pulse to the driver |
| dir_o | output | 1 | Direction level to the driver |
| busy_o | output | 1 | High while a pulse, gap or setup runs or a request is held |
| pos_o | output | POS_W | Position count |

## Verification
The bench measures every pulse and gap from the outside. A counter that was loaded off by one would show up as a pulse one cycle too long or too short, and a width of 0 that was not clamped would give a pulse of 256 cycles. It times each direction reversal against the next step edge: a design that skipped the setup on a reversal, or applied it to every step, would miss the exact SETUP_CYC distance, or make a same-direction step late. Back-to-back requests test the single hold slot. A design that dropped the held request, or that let a third one in, would end with a position different from the bench's running sum. A down step at zero, followed by an up step, catches a count that saturates instead of wrapping.

// File: rtl/step_dir_pkg.sv
package step_dir_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SETUP = 2'd1,
        ST_PULSE = 2'd2,
        ST_GAP   = 2'd3
    } sd_state_e;

endpackage

// File: rtl/step_pos_count.sv
module step_pos_count #(
    parameter int POS_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fire_i,
    input  logic             up_i,
    output logic [POS_W-1:0] pos_o
);

    logic [POS_W-1:0] pos_d, pos_q;

    always_comb begin
        pos_d = pos_q;
        if (fire_i) begin
            pos_d = up_i ? pos_q + POS_W'(1) : pos_q - POS_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pos_q <= '0;
        else        pos_q <= pos_d;
    end

    assign pos_o = pos_q;

    // R5: a step moves the count by exactly one in the step's direction
    p_pos_track_r5: assert property (@(posedge clk) disable iff (!rst_n)
        fire_i |=> pos_q == ($past(up_i) ? $past(pos_q) + POS_W'(1)
                                         : $past(pos_q) - POS_W'(1)));

    // R5: no step, no movement
    p_pos_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !fire_i |=> $stable(pos_q));

endmodule

// File: rtl/step_seq.sv
module step_seq
    import step_dir_pkg::*;
#(
    parameter int WIDTH_W   = 8,
    parameter int SETUP_CYC = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid_i,
    input  logic               req_dir_i,
    input  logic [WIDTH_W-1:0] cfg_width_i,
    output logic               fire_o,
    output logic               up_o,
    output logic               pulse_o,
    output logic               dir_o,
    output logic               busy_o
);

    localparam int SETUP_W = $clog2(SETUP_CYC + 1);
    localparam int CNT_W   = (SETUP_W > WIDTH_W) ? SETUP_W : WIDTH_W;

    typedef struct packed {
        sd_state_e          state;
        logic [CNT_W-1:0]   cnt;
        logic [WIDTH_W-1:0] width;
        logic               dir;
        logic               pend;
        logic               pend_dir;
    } seq_t;

    seq_t seq_d, seq_q;
    logic [WIDTH_W-1:0] w_norm;
    logic               next_dir;
    logic               fire;

    assign w_norm = (cfg_width_i == '0) ? WIDTH_W'(1) : cfg_width_i;

    always_comb begin
        seq_d    = seq_q;
        fire     = 1'b0;
        next_dir = seq_q.pend ? seq_q.pend_dir : req_dir_i;
        unique case (seq_q.state)
            ST_IDLE: begin
                if (seq_q.pend || req_valid_i) begin
                    seq_d.pend  = 1'b0;
                    seq_d.width = w_norm;
                    if (next_dir != seq_q.dir) begin
                        seq_d.dir   = next_dir;
                        seq_d.state = ST_SETUP;
                        seq_d.cnt   = CNT_W'(SETUP_CYC - 1);
                    end else begin
                        seq_d.state = ST_PULSE;
                        seq_d.cnt   = CNT_W'(w_norm) - CNT_W'(1);
                        fire        = 1'b1;
                    end
                end
            end
            ST_SETUP: begin
                if (seq_q.cnt == '0) begin
                    seq_d.state = ST_PULSE;
                    seq_d.cnt   = CNT_W'(seq_q.width) - CNT_W'(1);
                    fire        = 1'b1;
                end else begin
                    seq_d.cnt = seq_q.cnt - CNT_W'(1);
                end
            end
            ST_PULSE: begin
                if (seq_q.cnt == '0) begin
                    seq_d.state = ST_GAP;
                    seq_d.cnt   = CNT_W'(seq_q.width) - CNT_W'(1);
                end else begin
                    seq_d.cnt = seq_q.cnt - CNT_W'(1);
                end
            end
            default: begin
                if (seq_q.cnt == '0) seq_d.state = ST_IDLE;
                else                 seq_d.cnt   = seq_q.cnt - CNT_W'(1);
            end
        endcase
        if (seq_q.state != ST_IDLE && req_valid_i && !seq_q.pend) begin
            seq_d.pend     = 1'b1;
            seq_d.pend_dir = req_dir_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '{state: ST_IDLE, cnt: '0, width: WIDTH_W'(1),
                       dir: 1'b0, pend: 1'b0, pend_dir: 1'b0};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign fire_o  = fire;
    assign up_o    = seq_q.dir;
    assign pulse_o = (seq_q.state == ST_PULSE);
    assign dir_o   = seq_q.dir;
    assign busy_o  = (seq_q.state != ST_IDLE) || seq_q.pend;

    // Observation counters for the timing properties below
    logic [WIDTH_W:0] pulse_len_q;
    logic [CNT_W:0]   setup_len_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pulse_len_q <= '0;
            setup_len_q <= '0;
        end else begin
            pulse_len_q <= (seq_q.state == ST_PULSE) ? pulse_len_q + 1'b1 : '0;
            setup_len_q <= (seq_q.state == ST_SETUP) ? setup_len_q + 1'b1 : '0;
        end
    end

    // R2: a finished pulse lasted exactly the latched width
    p_pulse_width_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.state == ST_GAP && $past(seq_q.state) == ST_PULSE)
            |-> pulse_len_q == {1'b0, seq_q.width});

    // R2: the latched width is never zero
    p_width_nonzero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        seq_q.width != '0);

    // R4: a step after a reversal waited the full setup time
    p_setup_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.state == ST_PULSE && $past(seq_q.state) == ST_SETUP)
            |-> setup_len_q == (CNT_W+1)'(SETUP_CYC));

    // R4: direction only moves on entry to the setup phase
    p_dir_in_setup_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.dir != $past(seq_q.dir)) |-> seq_q.state == ST_SETUP);

    // R8: a held request is taken up as soon as the sequencer is idle
    p_held_served_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.state == ST_IDLE && seq_q.pend)
            |=> (!seq_q.pend && seq_q.state != ST_IDLE));

endmodule

// File: rtl/step_dir_gen.sv
module step_dir_gen #(
    parameter int POS_W     = 24,
    parameter int WIDTH_W   = 8,
    parameter int SETUP_CYC = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid_i,
    input  logic               req_dir_i,
    input  logic [WIDTH_W-1:0] cfg_width_i,
    input  logic               cfg_active_high_i,
    output logic               step_o,
    output logic               dir_o,
    output logic               busy_o,
    output logic [POS_W-1:0]   pos_o
);

    logic fire;
    logic up;
    logic pulse;

    step_seq #(
        .WIDTH_W   (WIDTH_W),
        .SETUP_CYC (SETUP_CYC)
    ) i_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid_i (req_valid_i),
        .req_dir_i   (req_dir_i),
        .cfg_width_i (cfg_width_i),
        .fire_o      (fire),
        .up_o        (up),
        .pulse_o     (pulse),
        .dir_o       (dir_o),
        .busy_o      (busy_o)
    );

    step_pos_count #(
        .POS_W (POS_W)
    ) i_pos (
        .clk    (clk),
        .rst_n  (rst_n),
        .fire_i (fire),
        .up_i   (up),
        .pos_o  (pos_o)
    );

    assign step_o = pulse ? cfg_active_high_i : ~cfg_active_high_i;

    // R3: an idle generator holds the step line at its inactive level
    p_idle_level_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> step_o == ~cfg_active_high_i);

    // R1: outputs come out of reset in their rest state
    p_reset_state_r1: assert property (@(posedge clk)
        $rose(rst_n) |-> (!busy_o && !dir_o && pos_o == '0));

endmodule

// File: tb/test_step_dir_gen.sv
module test_step_dir_gen;

    localparam int SETUP = 16;
    localparam int PW    = 24;
    localparam int WW    = 8;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          req_valid;
    logic          req_dir;
    logic [WW-1:0] cfg_width;
    logic          cfg_pol;
    logic          step_o;
    logic          dir_o;
    logic          busy_o;
    logic [PW-1:0] pos_o;

    always #10 clk = ~clk;

    step_dir_gen #(.POS_W(PW), .WIDTH_W(WW), .SETUP_CYC(SETUP)) i_step_dir_gen (
        .clk               (clk),
        .rst_n             (rst_n),
        .req_valid_i       (req_valid),
        .req_dir_i         (req_dir),
        .cfg_width_i       (cfg_width),
        .cfg_active_high_i (cfg_pol),
        .step_o            (step_o),
        .dir_o             (dir_o),
        .busy_o            (busy_o),
        .pos_o             (pos_o)
    );

    int            n_chk  = 0;
    int            n_fail = 0;
    int            m_chk  = 0;
    int            m_fail = 0;
    int            cur_w  = 3;
    int            epoch  = 0;
    logic [PW-1:0] exp_pos;

    function automatic int norm_w(int w);
        return (w == 0) ? 1 : w;
    endfunction

    function automatic logic [PW-1:0] move(logic [PW-1:0] p, logic d);
        return d ? p + PW'(1) : p - PW'(1);
    endfunction

    function automatic int report(bit ok, string req, string what, longint act, longint exp);
        if (!ok) $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        return ok ? 0 : 1;
    endfunction

    task automatic chk(bit ok, string req, string what, longint act, longint exp);
        n_chk++;
        n_fail += report(ok, req, what, act, exp);
    endtask

    task automatic do_req(logic d);
        @(negedge clk);
        req_valid = 1'b1;
        req_dir   = d;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic wait_idle();
        while (busy_o) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic set_cfg(int w, logic pol);
        cfg_width = WW'(w);
        cfg_pol   = pol;
        cur_w     = norm_w(w);
        epoch++;
    endtask

    // Pulse-train monitor: widths, gaps, setup distance, position tracking
    logic          m_prev_act, m_prev_dir, m_dir_chg, m_have_prior;
    logic [PW-1:0] m_prev_pos;
    int            m_high, m_low, m_age, m_epoch;

    always @(negedge clk) begin
        logic act;
        if (!rst_n) begin
            m_prev_act = 1'b0; m_prev_dir = 1'b0; m_dir_chg = 1'b0;
            m_have_prior = 1'b0; m_prev_pos = '0;
            m_high = 0; m_low = 0; m_age = 0; m_epoch = epoch;
        end else begin
            act = (step_o === cfg_pol);
            if (m_epoch != epoch) begin
                m_epoch = epoch;
                m_have_prior = 1'b0;
            end
            if (dir_o != m_prev_dir) begin
                m_chk++;
                m_fail += report(!act && !m_prev_act, "R4", "dir moved during step", act, 0);
                m_age = 0;
                m_dir_chg = 1'b1;
            end else begin
                m_age++;
            end
            if (act && !m_prev_act) begin
                m_chk++;
                m_fail += report(pos_o == move(m_prev_pos, dir_o), "R5", "pos at step",
                                 pos_o, move(m_prev_pos, dir_o));
                if (m_dir_chg) begin
                    m_chk++;
                    m_fail += report(m_age == SETUP, "R4", "dir-to-step distance", m_age, SETUP);
                    m_dir_chg = 1'b0;
                end
                if (m_have_prior) begin
                    m_chk++;
                    m_fail += report(m_low >= cur_w, "R6", "gap between steps", m_low, cur_w);
                end
                m_high = 1;
                m_have_prior = 1'b1;
            end else begin
                m_chk++;
                m_fail += report(pos_o == m_prev_pos, "R5", "pos moved without step",
                                 pos_o, m_prev_pos);
                if (act) m_high++;
            end
            if (!act && m_prev_act) begin
                m_chk++;
                m_fail += report(m_high == cur_w, "R2", "pulse width", m_high, cur_w);
                m_low = 1;
            end else if (!act) begin
                m_low++;
            end
            m_prev_act = act;
            m_prev_dir = dir_o;
            m_prev_pos = pos_o;
        end
    end

    task automatic summary(int extra_fail);
        int tot, bad;
        tot = n_chk + m_chk + extra_fail;
        bad = n_fail + m_fail + extra_fail;
        $display("%0d/%0d checks passed", tot - bad, tot);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        $display("FAIL watchdog: actual timeout expected completion");
        summary(1);
        $finish;
    end

    initial begin
        rst_n     = 1'b0;
        req_valid = 1'b0;
        req_dir   = 1'b0;
        set_cfg(3, 1'b1);
        exp_pos   = '0;
        repeat (3) @(negedge clk);
        // R1 during reset
        chk(step_o == 1'b0, "R1", "step in reset", step_o, 0);
        chk(pos_o == '0, "R1", "pos in reset", pos_o, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(step_o == 1'b0 && dir_o == 1'b0, "R1", "step/dir after reset", {step_o, dir_o}, 0);
        chk(busy_o == 1'b0, "R1", "busy after reset", busy_o, 0);
        chk(pos_o == '0, "R1", "pos after reset", pos_o, 0);

        // R7 and R9: same-direction down step from zero
        do_req(1'b0);
        exp_pos = move(exp_pos, 1'b0);
        chk(step_o == 1'b1, "R7", "step on next edge", step_o, 1);
        chk(pos_o == {PW{1'b1}}, "R9", "wrap below zero", pos_o, {PW{1'b1}});
        wait_idle();

        // R4 and R9: reversal, then wrap back to zero
        do_req(1'b1);
        exp_pos = move(exp_pos, 1'b1);
        chk(dir_o == 1'b1, "R4", "dir switches on accept", dir_o, 1);
        chk(step_o == 1'b0, "R4", "no step during setup", step_o, 0);
        wait_idle();
        chk(pos_o == '0, "R9", "wrap above all ones", pos_o, 0);

        // R8: one held request, a third one ignored
        do_req(1'b1);
        exp_pos = move(exp_pos, 1'b1);
        do_req(1'b0);
        exp_pos = move(exp_pos, 1'b0);
        chk(busy_o == 1'b1, "R8", "busy while held", busy_o, 1);
        do_req(1'b1);
        wait_idle();
        chk(pos_o == exp_pos, "R8", "pos after hold", pos_o, exp_pos);
        chk(dir_o == 1'b0, "R8", "held dir applied, extra ignored", dir_o, 0);

        // R2: width zero acts as one
        set_cfg(0, 1'b1);
        do_req(1'b0);
        exp_pos = move(exp_pos, 1'b0);
        chk(step_o == 1'b1, "R2", "zero-width pulse asserted", step_o, 1);
        @(negedge clk);
        chk(step_o == 1'b0, "R2", "zero-width pulse one cycle", step_o, 0);
        wait_idle();

        // R3: inverted polarity
        set_cfg(2, 1'b0);
        @(negedge clk);
        chk(step_o == 1'b1, "R3", "idle level inverted", step_o, 1);
        do_req(1'b0);
        exp_pos = move(exp_pos, 1'b0);
        chk(step_o == 1'b0, "R3", "asserted level inverted", step_o, 0);
        wait_idle();

        // Random traffic with fixed seed
        void'($urandom(32'd20240607));
        for (int i = 0; i < 240; i++) begin
            if (i % 20 == 0) set_cfg(int'($urandom_range(0, 6)), logic'($urandom_range(0, 1)));
            repeat ($urandom_range(0, 3)) @(negedge clk);
            begin
                logic d;
                d = logic'($urandom_range(0, 1));
                do_req(d);
                exp_pos = move(exp_pos, d);
            end
            if ($urandom_range(0, 2) == 0) begin
                logic d2;
                repeat ($urandom_range(0, 3)) @(negedge clk);
                d2 = logic'($urandom_range(0, 1));
                do_req(d2);
                exp_pos = move(exp_pos, d2);
            end
            wait_idle();
        end
        chk(pos_o == exp_pos, "R5", "final position", pos_o, exp_pos);

        summary(0);
        $finish;
    end

endmodule